// File: doc/BRIEF.md
# Memory Self-Test Address Sweep Sequencer

This block drives the address side of a memory self-test. After a synchronous reset it holds the address at zero for a fixed number of cycles. It then counts the address up by one per cycle from zero to a terminal value, and counts it back down by one per cycle to zero. It then parks in a finished state and raises a one-cycle completion pulse. A start-permit input can hold the sequencer at the end of its startup wait until the surrounding test logic is ready.

The control is split into three parts:
- A three-process state machine: a state register, combinational next-state logic and registered output logic.
- A startup wait timer that sits outside the state machine. The state machine enables it, and the timer reports back when the wait has expired.
- An address generator that steps according to the current phase.

Data writing, data compare and fault logging belong to neighbouring blocks.

Top module: `mbist_sweep_seq`

## Requirements
- R1: While `rst` is high, and on the first clock edge with it high, the outputs settle to `addr`=0, `phase_up`=0, `busy`=0, `sweep_done`=0, and the sequencer is in its wait state.
- R2: With `start_ok` held high, the wait state lasts exactly HOLD_CYCLES (default 500) cycles after reset is released, and `addr` stays 0 throughout.
- R3: The wait timer advances only while the state machine is in the wait state and is cleared in every other state. A later wait, entered through reset, therefore again lasts the full HOLD_CYCLES.
- R4: The sweep cannot start before both conditions hold: the wait has expired and `start_ok` is high. If `start_ok` is low when the wait expires, the sequencer stays waiting. The upward phase then begins on the first edge at which `start_ok` is sampled high, including the case where it rises in the very cycle the wait expires.
- R5: In the upward phase `phase_up`=1 and `busy`=1, and `addr` runs 0, 1, 2, … up to ADDR_TOP (default 1000), changing by exactly one each cycle.
- R6: The cycle after `addr` reaches ADDR_TOP, the downward phase begins: `phase_up`=0, `busy`=1, and `addr` runs ADDR_TOP-1 down to 0, changing by exactly one each cycle.
- R7: The cycle after `addr` reaches 0 in the downward phase, the sequencer enters its finished state. In that state `sweep_done` is 1 for exactly one cycle and `busy`=0 and `addr`=0. The sequencer stays there until reset, and `start_ok` has no effect in that state.
- R8: A reset asserted in the middle of a sweep returns the sequencer to the wait state with `addr`=0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_ok | input | 1 | Permission to leave the wait state |
| addr | output | ADDR_W (10) | Current test address |
| phase_up | output | 1 | High during the upward phase |
| busy | output | 1 | High during either sweep phase |
| sweep_done | output | 1 | One-cycle pulse on entering the finished state |

## Verification
Two events can land in the same cycle: the wait timer reaching its limit and `start_ok` becoming high. The bench creates this case by holding the permit low from reset and raising it just before the edge at which the timer reports expiry. The upward phase must then begin on exactly that edge, with neither a lost cycle nor an extra one. It also holds the permit low well past expiry, to confirm that the sequencer waits and that the timer stays saturated. It then checks that the sweep begins on the first edge after the permit rises.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,
    ST_UP   = 2'd1,
    ST_DOWN = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/mbist_wait_timer.sv
module mbist_wait_timer #(
  parameter int HOLD_CYCLES = 500,
  localparam int CW = $clog2(HOLD_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic cnt_en,
  output logic expired
);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] tick_q;

  // saturates at LIMIT while enabled; cleared whenever enable drops
  always_ff @(posedge clk) begin
    if (rst || !cnt_en) tick_q <= '0;
    else if (tick_q != LIMIT) tick_q <= tick_q + 1'b1;
  end

  assign expired = cnt_en && (tick_q == LIMIT);

  assert_clear_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> (tick_q == '0));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    tick_q <= LIMIT);
endmodule

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen
  import mbist_pkg::*;
#(
  parameter int ADDR_TOP = 1000,
  localparam int AW = $clog2(ADDR_TOP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  seq_state_t    state,
  output logic [AW-1:0] addr,
  output logic          at_top,
  output logic          at_zero
);
  localparam logic [AW-1:0] TOP = AW'(ADDR_TOP);

  logic [AW-1:0] addr_q;

  assign at_top  = (addr_q == TOP);
  assign at_zero = (addr_q == '0);

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else begin
      unique case (state)
        ST_UP:   addr_q <= at_top ? addr_q - 1'b1 : addr_q + 1'b1;
        ST_DOWN: addr_q <= at_zero ? '0 : addr_q - 1'b1;
        default: addr_q <= '0;
      endcase
    end
  end

  assign addr = addr_q;

  assert_step_up_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_UP && !at_top) |=> (addr_q == $past(addr_q) + 1'b1));

  assert_step_down_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DOWN && !at_zero) |=> (addr_q == $past(addr_q) - 1'b1));

  assert_wait_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |=> (addr_q == '0) || $past(state == ST_UP));
endmodule

// File: rtl/mbist_seq_fsm.sv
module mbist_seq_fsm
  import mbist_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_ok,
  input  logic       expired,
  input  logic       at_top,
  input  logic       at_zero,
  output seq_state_t state,
  output logic       cnt_en,
  output logic       phase_up,
  output logic       busy,
  output logic       sweep_done
);
  seq_state_t state_q, state_d;
  logic up_q, busy_q, done_q;

  // state register
  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_WAIT;
    else     state_q <= state_d;
  end

  // next-state logic
  always_comb begin
    state_d = seq_state_t'('x);
    unique case (state_q)
      ST_WAIT: state_d = (expired && start_ok) ? ST_UP : ST_WAIT;
      ST_UP:   state_d = at_top ? ST_DOWN : ST_UP;
      ST_DOWN: state_d = at_zero ? ST_FIN : ST_DOWN;
      ST_FIN:  state_d = ST_FIN;
      default: state_d = seq_state_t'('x);
    endcase
  end

  // registered outputs, aligned with the state they belong to
  always_ff @(posedge clk) begin
    if (rst) begin
      up_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      up_q   <= (state_d == ST_UP);
      busy_q <= (state_d == ST_UP) || (state_d == ST_DOWN);
      done_q <= (state_d == ST_FIN) && (state_q != ST_FIN);
    end
  end

  assign state      = state_q;
  assign cnt_en     = (state_q == ST_WAIT);
  assign phase_up   = up_q;
  assign busy       = busy_q;
  assign sweep_done = done_q;

  assert_permit_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !start_ok) |=> (state_q == ST_WAIT));

  assert_fin_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIN) |=> (state_q == ST_FIN));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    sweep_done |=> !sweep_done);

  assert_phase_in_busy_R5: assert property (@(posedge clk) disable iff (rst)
    phase_up |-> busy);
endmodule

// File: rtl/mbist_sweep_seq.sv
module mbist_sweep_seq
  import mbist_pkg::*;
#(
  parameter int HOLD_CYCLES = 500,
  parameter int ADDR_TOP    = 1000,
  localparam int ADDR_W     = $clog2(ADDR_TOP + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_ok,
  output logic [ADDR_W-1:0] addr,
  output logic              phase_up,
  output logic              busy,
  output logic              sweep_done
);
  seq_state_t state;
  logic cnt_en, expired, at_top, at_zero;

  mbist_wait_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .expired(expired)
  );

  mbist_seq_fsm u_fsm (
    .clk(clk), .rst(rst), .start_ok(start_ok), .expired(expired),
    .at_top(at_top), .at_zero(at_zero), .state(state), .cnt_en(cnt_en),
    .phase_up(phase_up), .busy(busy), .sweep_done(sweep_done)
  );

  mbist_addr_gen #(.ADDR_TOP(ADDR_TOP)) u_addr (
    .clk(clk), .rst(rst), .state(state), .addr(addr),
    .at_top(at_top), .at_zero(at_zero)
  );

  assert_reset_clean_R8: assert property (@(posedge clk)
    rst |=> (addr == '0 && !busy && !phase_up && !sweep_done));
endmodule

// File: tb/test_mbist_sweep_seq.sv
module test_mbist_sweep_seq;
  localparam int HOLD = 500;
  localparam int TOP  = 1000;
  localparam int AW   = $clog2(TOP + 1);
  localparam int FIN  = HOLD + 2 * TOP + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_ok = 1'b1;
  logic [AW-1:0] addr;
  logic phase_up, busy, sweep_done;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mbist_sweep_seq #(.HOLD_CYCLES(HOLD), .ADDR_TOP(TOP)) i_mbist_sweep_seq (
    .clk(clk), .rst(rst), .start_ok(start_ok), .addr(addr),
    .phase_up(phase_up), .busy(busy), .sweep_done(sweep_done)
  );

  // vector: {edge index after reset release, addr, phase_up, busy, done}
  typedef struct packed {
    logic [15:0] n;
    logic [15:0] a;
    logic        up;
    logic        bz;
    logic        dn;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{16'd0,           16'd0,       1'b0, 1'b0, 1'b0},
    '{16'(HOLD-1),     16'd0,       1'b0, 1'b0, 1'b0},
    '{16'(HOLD),       16'd0,       1'b1, 1'b1, 1'b0},
    '{16'(HOLD+1),     16'd1,       1'b1, 1'b1, 1'b0},
    '{16'(HOLD+TOP),   16'(TOP),    1'b1, 1'b1, 1'b0},
    '{16'(HOLD+TOP+1), 16'(TOP-1),  1'b0, 1'b1, 1'b0},
    '{16'(FIN-1),      16'd0,       1'b0, 1'b1, 1'b0},
    '{16'(FIN),        16'd0,       1'b0, 1'b0, 1'b1},
    '{16'(FIN+1),      16'd0,       1'b0, 1'b0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int n);
    if (n < HOLD) return "R2";
    if (n <= HOLD + TOP) return "R5";
    if (n < FIN) return "R6";
    return "R7";
  endfunction

  function automatic int exp_addr(input int n);
    if (n < HOLD) return 0;
    if (n <= HOLD + TOP) return n - HOLD;
    if (n < FIN) return TOP - (n - HOLD - TOP);
    return 0;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic step(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int vi;
    int bad_cycles;
    // R1: outputs during reset
    step(2);
    check(addr == 0 && !busy && !phase_up && !sweep_done, "R1", "reset outputs",
          {busy, phase_up, sweep_done}, 0);
    rst = 1'b0; // released at a negedge: observation index 0
    vi = 0;
    bad_cycles = 0;
    for (int n = 0; n <= FIN + 20; n++) begin
      int ea;
      bit eu, eb, ed;
      ea = exp_addr(n);
      eu = (n >= HOLD && n <= HOLD + TOP);
      eb = (n >= HOLD && n < FIN);
      ed = (n == FIN);
      if (addr != AW'(ea) || phase_up != eu || busy != eb || sweep_done != ed) begin
        if (bad_cycles < 5)
          check(1'b0, req_of(n), $sformatf("sweep cycle %0d addr", n), int'(addr), ea);
        bad_cycles++;
      end
      if (vi < 9 && int'(VECS[vi].n) == n) begin
        check(addr == AW'(VECS[vi].a) && phase_up == VECS[vi].up &&
              busy == VECS[vi].bz && sweep_done == VECS[vi].dn,
              req_of(n), $sformatf("vector %0d addr", vi), int'(addr), int'(VECS[vi].a));
        vi++;
      end
      if (n == FIN + 5) start_ok = 1'b0; // R7: permit ignored when finished
      if (n == FIN + 10) start_ok = 1'b1;
      step(1);
    end
    check(bad_cycles == 0, "R5", "sequence mismatching cycles", bad_cycles, 0);
    check(addr == 0 && !busy && !sweep_done, "R7", "still finished", int'(addr), 0);

    // R8: reset mid sweep
    do_reset();
    step(HOLD + 300);
    check(busy && phase_up, "R8", "mid-sweep before reset busy", busy, 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(addr == 0 && !busy && !phase_up, "R8", "addr after mid reset", int'(addr), 0);
    rst = 1'b0;
    // R3: second wait is full length again
    step(HOLD - 1);
    check(!busy && addr == 0, "R3", "still waiting at HOLD-1", busy, 0);
    step(1);
    check(busy && phase_up && addr == 0, "R3", "sweep starts at HOLD", busy, 1);

    // R4: permit low past expiry
    start_ok = 1'b0;
    do_reset();
    step(HOLD + 100);
    check(!busy && addr == 0, "R4", "waiting without permit", busy, 0);
    start_ok = 1'b1;
    step(1);
    check(busy && phase_up && addr == 0, "R4", "start after permit", busy, 1);
    step(1);
    check(addr == 1, "R4", "first step after permit", int'(addr), 1);

    // R4: permit rises in the expiry cycle
    start_ok = 1'b0;
    do_reset();
    step(HOLD - 1);
    check(!busy, "R4", "no start before permit", busy, 0);
    start_ok = 1'b1;
    step(1);
    check(busy && phase_up && addr == 0, "R4", "coincident permit and expiry", busy, 1);

    // R4: permit rising one cycle early does not shorten the wait
    start_ok = 1'b0;
    do_reset();
    step(HOLD - 2);
    start_ok = 1'b1;
    step(1);
    check(!busy, "R4", "early permit does not shorten wait", busy, 0);
    step(1);
    check(busy, "R4", "start at expiry", busy, 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule